// File: doc/BRIEF.md
# Go-Back-N Link Transmit Buffer

This block sits on the transmit side of one router port. Uncoded flits come in from the switch fabric over a ready/valid handshake and are held in a small ring of storage. The ring is read in order, and each flit is protected with a single-error Hamming code as it leaves for the link. Because the code is added after storage, the ring holds only payload bits, with no check bits.

A flit that has gone out stays in the ring for a fixed round-trip window. If no negative acknowledge arrives in that window, its slot is released. When a negative acknowledge does arrive, the read position jumps back to the oldest flit not yet released, and every flit from there on is sent again in its original order (go-back-N). A build parameter can turn the block into a plain FIFO. In that mode a slot is freed the moment its flit is sent, and negative acknowledges are ignored.

Top module: `gbn_out_channel`

## Requirements
- R1: After reset, `linkValid` is 0 and `inReady` is 1.
- R2: Flits leave on the link in the order they were accepted, one per cycle while any are waiting. A flit accepted at clock edge E can appear on the link after edge E+1 at the earliest.
- R3: `linkFlit` is a 38-bit Hamming word. Number its bit i (0-based) as position i+1. Then the XOR of the positions of all set bits is zero. The 32 payload bits occupy the positions that are not powers of two, in ascending order, with payload bit 0 lowest.
- R4: `inReady` falls when DEPTH (4) flits are held but not yet released. While `inReady` is 0, an offered flit is not stored and never appears on the link.
- R5: In retransmit mode, a sent flit's slot is released at the RTT-th (4th) clock edge after the edge that sent it, provided no negative acknowledge came in between. A negative acknowledge after release does not cause that flit to be sent again.
- R6: When `nack` is sampled high in retransmit mode, the next flits on the link are the oldest unreleased flit and then all flits after it, in their original order.
- R7: In the cycle after `nack` is sampled high in retransmit mode, `linkValid` is 0.
- R8: In FIFO mode (`USE_ARQ`=0), `nack` has no effect. Every flit is sent exactly once, and a slot is released as soon as its flit is sent.
- R9: `linkValid` stays 0 when no flit is waiting to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Fabric offers a flit |
| inFlit | input | DATA_W (32) | Uncoded flit from the fabric |
| inReady | output | 1 | Buffer can take a flit this cycle |
| nack | input | 1 | Negative acknowledge from the downstream receiver |
| linkValid | output | 1 | A coded flit is on the link |
| linkFlit | output | CODE_W (38) | Hamming-coded flit to the link |

## Verification
Suppose the write or acknowledge pointer held a wrong value. `inReady` would then fall or rise on the wrong edge, and the bench checks this on the exact edges computed for a full ring and the 4-cycle release. A wrong send pointer shows up as flits out of order, duplicated, missing or extra in the link log. For a rewind, this is visible within a few cycles of the negative acknowledge. A fault in the encoder breaks the position-XOR or payload extraction that the bench applies to every word leaving the block.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  localparam int IDX_W = 8;

  // Smallest r with 2^r >= dataW + r + 1 (single-error Hamming check width).
  function automatic int calcChkBits(input int dataW);
    int r;
    r = 1;
    while ((1 << r) < dataW + r + 1) r++;
    return r;
  endfunction

  // Control-to-datapath strobes.
  typedef struct packed {
    logic             wrEn;
    logic             sendEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } gbnStrobe_t;
endpackage

// File: rtl/gbn_hamming_enc.sv
module gbn_hamming_enc
  import gbn_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CHK_W  = calcChkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut
);
  always_comb begin
    logic [CODE_W-1:0] cw;
    logic par;
    int d;
    cw = '0;
    d = 0;
    // Scatter payload into non-power-of-two positions.
    for (int pos = 1; pos <= CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos-1] = dataIn[d];
        d++;
      end
    end
    // Each check bit covers the positions whose index has that bit set.
    for (int j = 0; j < CHK_W; j++) begin
      par = 1'b0;
      for (int pos = 1; pos <= CODE_W; pos++) begin
        if (((pos >> j) & 1) == 1) par = par ^ cw[pos-1];
      end
      cw[(1 << j) - 1] = par;
    end
    codeOut = cw;
  end
endmodule

// File: rtl/gbn_out_dpath.sv
module gbn_out_dpath
  import gbn_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CHK_W  = calcChkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gbnStrobe_t        strb,
  input  logic [DATA_W-1:0] inFlit,
  output logic              linkValid,
  output logic [CODE_W-1:0] linkFlit
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] ring [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic [CODE_W-1:0] codeWord;
  logic [2*(IDX_W-AW)-1:0] unusedIdx;

  assign unusedIdx = {strb.wrIdx[IDX_W-1:AW], strb.rdIdx[IDX_W-1:AW]};

  always_ff @(posedge clk) begin
    if (strb.wrEn) ring[strb.wrIdx[AW-1:0]] <= inFlit;
  end

  assign rdData = ring[strb.rdIdx[AW-1:0]];

  gbn_hamming_enc #(.DATA_W(DATA_W)) u_enc (
    .dataIn (rdData),
    .codeOut(codeWord)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linkValid <= 1'b0;
      linkFlit  <= '0;
    end else begin
      linkValid <= strb.sendEn;
      if (strb.sendEn) linkFlit <= codeWord;
    end
  end
endmodule

// File: rtl/gbn_out_ctrl.sv
module gbn_out_ctrl
  import gbn_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int RTT     = 4,
  parameter bit USE_ARQ = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       nack,
  output logic       inReady,
  output gbnStrobe_t strb
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wrPtr, sendPtr, ackPtr, fill;
  logic nackEff, pending, sendEn, wrEn, retire;

  assign nackEff = nack & USE_ARQ;
  assign fill    = wrPtr - ackPtr;
  assign inReady = (fill != PW'(DEPTH));
  assign wrEn    = inValid & inReady;
  assign pending = (sendPtr != wrPtr);
  assign sendEn  = pending & ~nackEff;

  generate
    if (USE_ARQ) begin : g_arq
      // One bit per sent flit, shifting once per cycle; the bit leaving
      // the top marks the oldest outstanding flit as safe.
      logic [RTT-1:0] agePipe;
      always_ff @(posedge clk) begin
        if (!rst_n)       agePipe <= '0;
        else if (nackEff) agePipe <= '0;
        else              agePipe <= {agePipe[RTT-2:0], sendEn};
      end
      assign retire = agePipe[RTT-1] & ~nackEff;
    end else begin : g_fifo
      assign retire = sendEn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      sendPtr <= '0;
      ackPtr  <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + PW'(1);
      if (nackEff)     sendPtr <= ackPtr;
      else if (sendEn) sendPtr <= sendPtr + PW'(1);
      if (retire) ackPtr <= ackPtr + PW'(1);
    end
  end

  assign strb.wrEn   = wrEn;
  assign strb.sendEn = sendEn;
  assign strb.wrIdx  = IDX_W'(wrPtr[AW-1:0]);
  assign strb.rdIdx  = IDX_W'(sendPtr[AW-1:0]);
endmodule

// File: rtl/gbn_out_channel.sv
module gbn_out_channel
  import gbn_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int RTT     = 4,
  parameter bit USE_ARQ = 1'b1,
  localparam int CHK_W  = calcChkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inFlit,
  output logic              inReady,
  input  logic              nack,
  output logic              linkValid,
  output logic [CODE_W-1:0] linkFlit
);
  gbnStrobe_t strb;

  gbn_out_ctrl #(.DEPTH(DEPTH), .RTT(RTT), .USE_ARQ(USE_ARQ)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .inValid(inValid),
    .nack   (nack),
    .inReady(inReady),
    .strb   (strb)
  );

  gbn_out_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .inFlit   (inFlit),
    .linkValid(linkValid),
    .linkFlit (linkFlit)
  );
endmodule

// File: rtl/gbn_out_channel_chk.sv
module gbn_out_channel_chk
  import gbn_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter bit USE_ARQ = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       inValid,
  input logic       inReady,
  input logic       nack,
  input logic       linkValid,
  input gbnStrobe_t strb
);
  localparam int AW = $clog2(DEPTH);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!linkValid && inReady));

  p_send_gives_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sendEn |=> linkValid);

  p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.sendEn && $past(strb.sendEn) && !(USE_ARQ && $past(nack)))
      |-> (strb.rdIdx[AW-1:0] == $past(strb.rdIdx[AW-1:0]) + AW'(1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrEn |-> (inReady && inValid));

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.sendEn |=> !linkValid);

  generate
    if (USE_ARQ) begin : g_arq_chk
      p_nack_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nack |=> !linkValid);
    end
  endgenerate
endmodule

bind gbn_out_channel gbn_out_channel_chk #(.DEPTH(DEPTH), .USE_ARQ(USE_ARQ)) u_chk (.*);

// File: tb/gbn_out_channel_tb.sv
module gbn_out_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Retransmit-mode instance
  logic inValidA = 1'b0, nackA = 1'b0, inReadyA, linkValidA;
  logic [31:0] inFlitA = '0;
  logic [37:0] linkFlitA;
  // FIFO-mode instance
  logic inValidF = 1'b0, nackF = 1'b0, inReadyF, linkValidF;
  logic [31:0] inFlitF = '0;
  logic [37:0] linkFlitF;

  gbn_out_channel u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValidA), .inFlit(inFlitA),
    .inReady(inReadyA), .nack(nackA), .linkValid(linkValidA), .linkFlit(linkFlitA));

  gbn_out_channel #(.USE_ARQ(1'b0)) u_fifo (
    .clk(clk), .rst_n(rst_n), .inValid(inValidF), .inFlit(inFlitF),
    .inReady(inReadyF), .nack(nackF), .linkValid(linkValidF), .linkFlit(linkFlitF));

  logic [31:0] logA [64];
  logic [31:0] logF [64];
  int logNA = 0;
  int logNF = 0;

  function automatic logic [31:0] payload(input int k);
    return (32'(k) * 32'h9E3779B9) ^ 32'h0F0F1234;
  endfunction

  function automatic bit syndromeZero(input logic [37:0] cw);
    int s;
    s = 0;
    for (int pos = 1; pos <= 38; pos++) if (cw[pos-1]) s = s ^ pos;
    return s == 0;
  endfunction

  function automatic logic [31:0] extract(input logic [37:0] cw);
    logic [31:0] d;
    int n;
    d = '0;
    n = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d[n] = cw[pos-1];
        n++;
      end
    end
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Link monitors (sample away from the rising edge); R3 on every word.
  always @(negedge clk) begin
    if (rst_n && linkValidA) begin
      chk(syndromeZero(linkFlitA), "R3 position-xor", 64'(linkFlitA), 64'h0);
      if (logNA < 64) logA[logNA] = extract(linkFlitA);
      logNA++;
    end
    if (rst_n && linkValidF) begin
      chk(syndromeZero(linkFlitF), "R3 position-xor fifo", 64'(linkFlitF), 64'h0);
      if (logNF < 64) logF[logNF] = extract(linkFlitF);
      logNF++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(linkValidA == 1'b0, "R1 linkValid", 64'(linkValidA), 64'd0);
    chk(inReadyA == 1'b1, "R1 inReady", 64'(inReadyA), 64'd1);
    chk(inReadyF == 1'b1, "R1 inReady fifo", 64'(inReadyF), 64'd1);
    idle(5);
    // R9: nothing offered, nothing sent
    chk(logNA == 0, "R9 idle output", 64'(logNA), 64'd0);

    // R4/R5: fill the ring, offer junk while full, watch release timing
    logNA = 0;
    for (int i = 0; i < 4; i++) begin
      inValidA = 1'b1;
      inFlitA = payload(100 + i);
      @(negedge clk);
    end
    inFlitA = 32'hDEADBEEF;  // offered while full: must be dropped
    chk(inReadyA == 1'b0, "R4 full", 64'(inReadyA), 64'd0);
    @(negedge clk);
    inValidA = 1'b0;
    chk(inReadyA == 1'b0, "R5 held in window", 64'(inReadyA), 64'd0);
    @(negedge clk);
    chk(inReadyA == 1'b1, "R5 released after RTT", 64'(inReadyA), 64'd1);
    idle(10);
    chk(logNA == 4, "R4 no junk stored", 64'(logNA), 64'd4);
    for (int i = 0; i < 4; i++)
      chk(logA[i] == payload(100 + i), "R2 fill order", 64'(logA[i]), 64'(payload(100 + i)));

    // R2: bursts of 1..8 with back-pressure
    for (int len = 1; len <= 8; len++) begin
      logNA = 0;
      for (int i = 0; i < len; i++) begin
        bit rdy;
        inValidA = 1'b1;
        inFlitA = payload(len * 16 + i);
        do begin
          rdy = inReadyA;
          @(negedge clk);
        end while (!rdy);
      end
      inValidA = 1'b0;
      idle(12);
      chk(logNA == len, "R2 burst count", 64'(logNA), 64'(len));
      for (int i = 0; i < len; i++)
        chk(logA[i] == payload(len * 16 + i), "R2 burst order", 64'(logA[i]), 64'(payload(len * 16 + i)));
    end

    // R6/R7: rewind after three sends
    logNA = 0;
    for (int i = 0; i < 3; i++) begin
      inValidA = 1'b1;
      inFlitA = payload(200 + i);
      @(negedge clk);
    end
    inValidA = 1'b0;
    @(negedge clk);
    nackA = 1'b1;
    @(negedge clk);
    chk(linkValidA == 1'b0, "R7 gap after nack", 64'(linkValidA), 64'd0);
    nackA = 1'b0;
    idle(12);
    chk(logNA == 6, "R6 resend count", 64'(logNA), 64'd6);
    for (int i = 0; i < 6; i++)
      chk(logA[i] == payload(200 + (i % 3)), "R6 resend order", 64'(logA[i]), 64'(payload(200 + (i % 3))));

    // R5: nack after release has no effect
    logNA = 0;
    inValidA = 1'b1;
    inFlitA = payload(300);
    @(negedge clk);
    inValidA = 1'b0;
    idle(6);
    nackA = 1'b1;
    @(negedge clk);
    nackA = 1'b0;
    idle(8);
    chk(logNA == 1, "R5 late nack ignored", 64'(logNA), 64'd1);
    chk(logA[0] == payload(300), "R5 late nack data", 64'(logA[0]), 64'(payload(300)));

    // R8: FIFO mode, nack held high throughout
    logNF = 0;
    nackF = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inValidF = 1'b1;
      inFlitF = payload(400 + i);
      chk(inReadyF == 1'b1, "R8 fifo ready", 64'(inReadyF), 64'd1);
      @(negedge clk);
    end
    inValidF = 1'b0;
    idle(10);
    nackF = 1'b0;
    chk(logNF == 4, "R8 fifo count", 64'(logNF), 64'd4);
    for (int i = 0; i < 4; i++)
      chk(logF[i] == payload(400 + i), "R8 fifo order", 64'(logF[i]), 64'(payload(400 + i)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule